// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block is the device side of an ATA command channel. A host reaches it through an 8-bit register port with a 3-bit offset. Offset 0 is a 16-bit data window. The block keeps the sector count, the three LBA address bytes and the device-select byte. It accepts opcodes at offset 7 and returns a status byte from the same offset.

IDENTIFY is handled entirely inside the block. The block raises an interrupt and sets DRQ, then returns a computed identify table of `ID_WORDS` words, one word per data-port read. The table holds a serial string and a revision string, with the first character of each pair in the high byte, and a write-cache-enabled flag.

FLUSH CACHE raises a request line that stays up until an external done pulse arrives. READ DMA and WRITE DMA are handed to a DMA engine as a request carrying:
- a direction flag,
- a 24-bit start LBA,
- the raw sector count.

The engine's done pulse ends the command and raises the interrupt. A host read of the status byte clears the interrupt.

Top module: `ata_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0x40 (only DRDY set), the interrupt is low, and neither the flush request nor the DMA request is asserted.
- R2: Offsets 2 (sector count), 3, 4, 5 (LBA bytes) and 6 (device select, bit 4 = device 1, bit 6 = LBA mode) read back the last byte written while idle, in bits 7:0 with bits 15:8 zero.
- R3: Opcode 0xC8 (read DMA) raises `dma_req` with `dma_write` = 0, and opcode 0xCA (write DMA) raises it with `dma_write` = 1. `dma_lba` is {offset 5, offset 4, offset 3} and `dma_count` is the offset-2 byte. Status reads 0xC0 while the request is up. One cycle of `dma_done` drops the request, returns status to 0x40 and raises `irq`.
- R4: Opcode 0xEC (identify) raises `irq` and sets status to 0x48 (DRQ|DRDY). Status stays 0x48 across `ID_WORDS` data-port reads, and after the last read it is 0x40. Status bits are BSY = bit 7, DRDY = bit 6, DF = bit 5, DRQ = bit 3, ERR = bit 0.
- R5: Identify word k is returned on the k-th data read, counting from 0. Words SER_WORD to SER_WORD+9 carry the 20 serial bytes and words REV_WORD to REV_WORD+3 carry the 8 revision bytes. In both, the earlier byte is in bits 15:8. Word WCACHE_WORD is 0x0020 (bit 5 = write cache on). All other words are 0.
- R6: Opcode 0xE7 (flush) raises `flush_req` and status reads 0xC0 with no interrupt. One cycle of `flush_done` drops the request, returns status to 0x40 and raises `irq`.
- R7: A host read at offset 7 clears `irq` on the next cycle, unless a completion happens in that same cycle.
- R8: Writes to offsets 2 to 6 while BSY is set leave the stored bytes and `dma_lba`/`dma_count` unchanged.
- R9: An opcode written while BSY or DRQ is set is ignored.
- R10: Any other opcode written while idle sets status 0x41 (ERR|DRDY) and raises `irq`. ERR clears when the next valid command is accepted.
- R11: A data-port read while DRQ is clear returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 3 | Register offset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (side effects at offsets 0 and 7) |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 16 | Read data for the current offset (combinational) |
| irq | output | 1 | Interrupt request |
| flush_req | output | 1 | Cache flush outstanding |
| flush_done | input | 1 | Flush completion pulse |
| dma_req | output | 1 | DMA transfer requested |
| dma_write | output | 1 | 1 = host-to-media transfer |
| dma_lba | output | 24 | Start LBA |
| dma_count | output | 8 | Sector count byte |
| dma_done | input | 1 | DMA completion pulse |

## Verification
The bench builds the block with the default 256-word identify table. It overrides the defaults with a 20-byte serial string made of a short name padded with spaces, and the 8-byte revision string "v2.5    ".

With the full 256-word table, the bench reads the whole identify sequence. It therefore checks the DRQ edge after the very last word, the string boundaries at words 9/10, 19/20, 22/23 and 26/27, and the cache flag at word 85.

The padded strings make both the high-byte and the low-byte placement of every pair visible. The bench also covers:
- register writes and opcodes sent during BSY,
- an unknown opcode followed by identify, which clears ERR,
- both DMA directions with distinct LBA byte patterns.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IDENT,
        ST_FLUSH,
        ST_DMA
    } seq_state_e;

    localparam logic [7:0] OP_RD_DMA = 8'hC8;
    localparam logic [7:0] OP_WR_DMA = 8'hCA;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;
    localparam logic [7:0] OP_IDENT  = 8'hEC;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_CMDST = 3'd7;
    localparam int         TF_FIRST  = 2;
    localparam int         TF_REGS   = 5;

    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DF   = 5;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;

endpackage

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        busy,
    output logic [7:0]  rd_byte,
    output logic [23:0] lba,
    output logic [7:0]  count
);

    typedef struct packed {
        logic [TF_REGS-1:0][7:0] r;
    } tf_s;

    tf_s tf_d, tf_q;

    always_comb begin
        tf_d = tf_q;
        if (wr && !busy) begin
            for (int i = 0; i < TF_REGS; i++) begin
                if (addr == 3'(i + TF_FIRST)) begin
                    tf_d.r[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_q <= '0;
        end else begin
            tf_q <= tf_d;
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < TF_REGS; i++) begin
            if (addr == 3'(i + TF_FIRST)) begin
                rd_byte = tf_q.r[i];
            end
        end
    end

    assign count = tf_q.r[0];
    assign lba   = {tf_q.r[3], tf_q.r[2], tf_q.r[1]};

endmodule

// File: rtl/ata_id_table.sv
module ata_id_table #(
    parameter int ID_WORDS    = 256,
    parameter int SER_BYTES   = 20,
    parameter int REV_BYTES   = 8,
    parameter int SER_WORD    = 10,
    parameter int REV_WORD    = 23,
    parameter int WCACHE_WORD = 85,
    parameter int WCACHE_BIT  = 5,
    parameter logic [8*SER_BYTES-1:0] SERIAL   = "0123456789ABCDEFGHIJ",
    parameter logic [8*REV_BYTES-1:0] REVISION = "REV 1.00",
    localparam int IDX_W = $clog2(ID_WORDS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);

    localparam int SER_BITS  = 8 * SER_BYTES;
    localparam int REV_BITS  = 8 * REV_BYTES;
    localparam int SER_PAIRS = SER_BYTES / 2;
    localparam int REV_PAIRS = REV_BYTES / 2;

    always_comb begin
        word = 16'h0000;
        for (int k = 0; k < SER_PAIRS; k++) begin
            if (idx == IDX_W'(SER_WORD + k)) begin
                word = SERIAL[SER_BITS-1-16*k -: 16];
            end
        end
        for (int k = 0; k < REV_PAIRS; k++) begin
            if (idx == IDX_W'(REV_WORD + k)) begin
                word = REVISION[REV_BITS-1-16*k -: 16];
            end
        end
        if (idx == IDX_W'(WCACHE_WORD)) begin
            word[WCACHE_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/ata_cmd_ctrl.sv
module ata_cmd_ctrl
    import ata_seq_pkg::*;
#(
    parameter int ID_WORDS = 256,
    localparam int IDX_W = $clog2(ID_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_code,
    input  logic             status_rd,
    input  logic             data_rd,
    input  logic             flush_done,
    input  logic             dma_done,
    output logic             busy,
    output logic             drq,
    output logic             err,
    output logic             irq,
    output logic [IDX_W-1:0] idx,
    output logic             flush_req,
    output logic             dma_req,
    output logic             dma_write
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             irq;
        logic             err;
        logic             dir;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (status_rd) begin
            ctl_d.irq = 1'b0;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    ctl_d.err = 1'b0;
                    unique case (cmd_code)
                        OP_IDENT: begin
                            ctl_d.st  = ST_IDENT;
                            ctl_d.idx = '0;
                            ctl_d.irq = 1'b1;
                        end
                        OP_FLUSH: begin
                            ctl_d.st = ST_FLUSH;
                        end
                        OP_RD_DMA: begin
                            ctl_d.st  = ST_DMA;
                            ctl_d.dir = 1'b0;
                        end
                        OP_WR_DMA: begin
                            ctl_d.st  = ST_DMA;
                            ctl_d.dir = 1'b1;
                        end
                        default: begin
                            ctl_d.err = 1'b1;
                            ctl_d.irq = 1'b1;
                        end
                    endcase
                end
            end
            ST_IDENT: begin
                if (data_rd) begin
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.irq = 1'b1;
                end
            end
            ST_DMA: begin
                if (dma_done) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.irq = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, irq: 1'b0, err: 1'b0, dir: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st == ST_FLUSH) || (ctl_q.st == ST_DMA);
    assign drq       = (ctl_q.st == ST_IDENT);
    assign err       = ctl_q.err;
    assign irq       = ctl_q.irq;
    assign idx       = ctl_q.idx;
    assign flush_req = (ctl_q.st == ST_FLUSH);
    assign dma_req   = (ctl_q.st == ST_DMA);
    assign dma_write = ctl_q.dir;

endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
    import ata_seq_pkg::*;
#(
    parameter int ID_WORDS    = 256,
    parameter int SER_BYTES   = 20,
    parameter int REV_BYTES   = 8,
    parameter int SER_WORD    = 10,
    parameter int REV_WORD    = 23,
    parameter int WCACHE_WORD = 85,
    parameter logic [8*SER_BYTES-1:0] SERIAL   = "0123456789ABCDEFGHIJ",
    parameter logic [8*REV_BYTES-1:0] REVISION = "REV 1.00"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  hst_addr,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [7:0]  hst_wdata,
    output logic [15:0] hst_rdata,
    output logic        irq,
    output logic        flush_req,
    input  logic        flush_done,
    output logic        dma_req,
    output logic        dma_write,
    output logic [23:0] dma_lba,
    output logic [7:0]  dma_count,
    input  logic        dma_done
);

    localparam int IDX_W = $clog2(ID_WORDS);

    logic             busy, drq, err;
    logic [IDX_W-1:0] id_idx;
    logic [15:0]      id_word;
    logic [7:0]       tf_byte;
    logic [7:0]       status;

    logic is_cmd, is_data;
    assign is_cmd  = (hst_addr == OFS_CMDST);
    assign is_data = (hst_addr == OFS_DATA);

    ata_taskfile u_tf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hst_wr),
        .addr    (hst_addr),
        .wdata   (hst_wdata),
        .busy    (busy),
        .rd_byte (tf_byte),
        .lba     (dma_lba),
        .count   (dma_count)
    );

    ata_cmd_ctrl #(
        .ID_WORDS (ID_WORDS)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (hst_wr && is_cmd),
        .cmd_code   (hst_wdata),
        .status_rd  (hst_rd && is_cmd),
        .data_rd    (hst_rd && is_data),
        .flush_done (flush_done),
        .dma_done   (dma_done),
        .busy       (busy),
        .drq        (drq),
        .err        (err),
        .irq        (irq),
        .idx        (id_idx),
        .flush_req  (flush_req),
        .dma_req    (dma_req),
        .dma_write  (dma_write)
    );

    ata_id_table #(
        .ID_WORDS    (ID_WORDS),
        .SER_BYTES   (SER_BYTES),
        .REV_BYTES   (REV_BYTES),
        .SER_WORD    (SER_WORD),
        .REV_WORD    (REV_WORD),
        .WCACHE_WORD (WCACHE_WORD),
        .WCACHE_BIT  (5),
        .SERIAL      (SERIAL),
        .REVISION    (REVISION)
    ) u_id (
        .idx  (id_idx),
        .word (id_word)
    );

    always_comb begin
        status         = 8'h00;
        status[SB_BSY] = busy;
        status[SB_DRDY]= 1'b1;
        status[SB_DF]  = 1'b0;
        status[SB_DRQ] = drq;
        status[SB_ERR] = err;
    end

    always_comb begin
        if (is_data) begin
            hst_rdata = drq ? id_word : 16'h0000;
        end else if (is_cmd) begin
            hst_rdata = {8'h00, status};
        end else begin
            hst_rdata = {8'h00, tf_byte};
        end
    end

endmodule

module ata_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  hst_addr,
    input logic        hst_wr,
    input logic        hst_rd,
    input logic [15:0] hst_rdata,
    input logic        irq,
    input logic        flush_req,
    input logic        flush_done,
    input logic        dma_req,
    input logic [23:0] dma_lba,
    input logic [7:0]  dma_count,
    input logic        dma_done
);

    // R4: BSY and DRQ never show together
    a_r4_bsy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr == 3'd7) |-> !(hst_rdata[7] && hst_rdata[3]));

    // R6: outstanding flush reads as BSY|DRDY with no DRQ
    a_r6_flush_status: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && hst_addr == 3'd7) |-> (hst_rdata[7] && hst_rdata[6] && !hst_rdata[3]));

    // R6: flush completion drops the request and raises irq
    a_r6_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> (irq && !flush_req));

    // R3: DMA completion drops the request and raises irq
    a_r3_dma_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> (irq && !dma_req));

    // R7: a status read with no completion pending clears irq
    a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && hst_addr == 3'd7 && !hst_wr && !flush_done && !dma_done) |=> !irq);

    // R8: parameters stay stable while DMA is requested
    a_r8_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(dma_req)) |-> ($stable(dma_lba) && $stable(dma_count)));

    // R9: only one outstanding request kind
    a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && dma_req));

endmodule

bind ata_cmd_seq ata_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_addr   (hst_addr),
    .hst_wr     (hst_wr),
    .hst_rd     (hst_rd),
    .hst_rdata  (hst_rdata),
    .irq        (irq),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .dma_req    (dma_req),
    .dma_lba    (dma_lba),
    .dma_count  (dma_count),
    .dma_done   (dma_done)
);

// File: tb/tb_ata_cmd_seq.sv
module tb_ata_cmd_seq;

    localparam int CLK_P = 10;
    localparam int NWORDS = 256;
    localparam logic [159:0] TB_SER = "unit-disk-00        ";
    localparam logic [63:0]  TB_REV = "v2.5    ";

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_FRQ = 2;
    localparam int K_DMA = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  hst_addr = 3'd0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [7:0]  hst_wdata = 8'h00;
    logic [15:0] hst_rdata;
    logic        irq, flush_req, dma_req, dma_write;
    logic        flush_done = 1'b0;
    logic        dma_done = 1'b0;
    logic [23:0] dma_lba;
    logic [7:0]  dma_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int          kq[$];
    string       rq[$];
    logic [63:0] eq[$];

    always #(CLK_P/2) clk = ~clk;

    ata_cmd_seq #(
        .SERIAL   (TB_SER),
        .REVISION (TB_REV)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_addr   (hst_addr),
        .hst_wr     (hst_wr),
        .hst_rd     (hst_rd),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata),
        .irq        (irq),
        .flush_req  (flush_req),
        .flush_done (flush_done),
        .dma_req    (dma_req),
        .dma_write  (dma_write),
        .dma_lba    (dma_lba),
        .dma_count  (dma_count),
        .dma_done   (dma_done)
    );

    // Monitor: pops expected items and compares a quarter period after negedge
    always @(negedge clk) begin
        #(CLK_P/4);
        while (kq.size() > 0) begin
            int          k;
            string       r;
            logic [63:0] e, a;
            k = kq.pop_front();
            r = rq.pop_front();
            e = eq.pop_front();
            case (k)
                K_RD:    a = {48'h0, hst_rdata};
                K_IRQ:   a = {63'h0, irq};
                K_FRQ:   a = {63'h0, flush_req};
                default: a = {30'h0, dma_req, dma_write, dma_count, dma_lba};
            endcase
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual=%h expected=%h", r, a, e);
            end
        end
    end

    task automatic push(input int k, input string r, input logic [63:0] e);
        kq.push_back(k);
        rq.push_back(r);
        eq.push_back(e);
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr  = a;
        hst_wdata = d;
        hst_wr    = 1'b1;
        @(negedge clk);
        hst_wr    = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, input logic [15:0] e, input string r);
        @(negedge clk);
        hst_addr = a;
        hst_rd   = 1'b1;
        push(K_RD, r, {48'h0, e});
        @(negedge clk);
        hst_rd   = 1'b0;
    endtask

    task automatic observe(input int k, input logic [63:0] e, input string r);
        @(negedge clk);
        push(k, r, e);
    endtask

    task automatic pulse_dma_done();
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic pulse_flush_done();
        @(negedge clk);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
    endtask

    function automatic logic [15:0] exp_id(input int i);
        logic [15:0] w;
        w = 16'h0000;
        if (i >= 10 && i < 20) begin
            w = {TB_SER[159-8*(2*(i-10)) -: 8], TB_SER[159-8*(2*(i-10)+1) -: 8]};
        end else if (i >= 23 && i < 27) begin
            w = {TB_REV[63-8*(2*(i-23)) -: 8], TB_REV[63-8*(2*(i-23)+1) -: 8]};
        end else if (i == 85) begin
            w = 16'h0020;
        end
        return w;
    endfunction

    function automatic logic [63:0] dma_exp(input logic rq_, input logic wr_,
                                            input logic [7:0] c, input logic [23:0] l);
        return {30'h0, rq_, wr_, c, l};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_rd(3'd7, 16'h0040, "R1 status after reset");
        observe(K_IRQ, 64'd0, "R1 irq after reset");
        observe(K_FRQ, 64'd0, "R1 flush_req after reset");
        observe(K_DMA, 64'd0, "R1 dma idle after reset");

        // R2 register readback
        host_wr(3'd2, 8'h03);
        host_wr(3'd3, 8'h11);
        host_wr(3'd4, 8'h22);
        host_wr(3'd5, 8'h33);
        host_wr(3'd6, 8'h50);
        host_rd(3'd2, 16'h0003, "R2 count readback");
        host_rd(3'd3, 16'h0011, "R2 lba low readback");
        host_rd(3'd4, 16'h0022, "R2 lba mid readback");
        host_rd(3'd5, 16'h0033, "R2 lba high readback");
        host_rd(3'd6, 16'h0050, "R2 device bit4 readback");
        host_wr(3'd6, 8'h40);
        host_rd(3'd6, 16'h0040, "R2 device 0 readback");

        // R11 data read while idle
        host_rd(3'd0, 16'h0000, "R11 idle data read");
        host_rd(3'd7, 16'h0040, "R11 status unchanged");

        // R3 read DMA
        host_wr(3'd7, 8'hC8);
        observe(K_DMA, dma_exp(1'b1, 1'b0, 8'h03, 24'h332211), "R3 read dma request");
        host_rd(3'd7, 16'h00C0, "R3 status busy during dma");
        // R8 taskfile writes during BSY
        host_wr(3'd3, 8'hFF);
        host_wr(3'd2, 8'h77);
        observe(K_DMA, dma_exp(1'b1, 1'b0, 8'h03, 24'h332211), "R8 dma params held");
        // R9 opcode during BSY
        host_wr(3'd7, 8'hEC);
        observe(K_IRQ, 64'd0, "R9 no irq from ignored opcode");
        pulse_dma_done();
        observe(K_IRQ, 64'd1, "R3 irq on dma done");
        observe(K_DMA, dma_exp(1'b0, 1'b0, 8'h03, 24'h332211), "R3 request dropped");
        host_rd(3'd7, 16'h0040, "R9 status no DRQ after ignored identify");
        observe(K_IRQ, 64'd0, "R7 irq cleared by status read");
        host_rd(3'd3, 16'h0011, "R8 lba low kept");

        // R3 write DMA
        host_wr(3'd2, 8'h80);
        host_wr(3'd3, 8'h03);
        host_wr(3'd4, 8'h02);
        host_wr(3'd5, 8'h01);
        host_wr(3'd7, 8'hCA);
        observe(K_DMA, dma_exp(1'b1, 1'b1, 8'h80, 24'h010203), "R3 write dma request");
        pulse_dma_done();
        observe(K_IRQ, 64'd1, "R3 irq on write dma done");
        host_rd(3'd7, 16'h0040, "R3 status after write dma");
        observe(K_IRQ, 64'd0, "R7 irq cleared after write dma");

        // R6 flush
        host_wr(3'd7, 8'hE7);
        observe(K_FRQ, 64'd1, "R6 flush request");
        host_rd(3'd7, 16'h00C0, "R6 status during flush");
        observe(K_IRQ, 64'd0, "R6 no irq while flushing");
        repeat (5) @(negedge clk);
        observe(K_FRQ, 64'd1, "R6 flush held until done");
        pulse_flush_done();
        observe(K_IRQ, 64'd1, "R6 irq on flush done");
        observe(K_FRQ, 64'd0, "R6 flush request dropped");
        host_rd(3'd7, 16'h0040, "R6 status after flush");
        observe(K_IRQ, 64'd0, "R7 irq cleared after flush");

        // R10 unknown opcode
        host_wr(3'd7, 8'h5A);
        observe(K_IRQ, 64'd1, "R10 irq on unknown opcode");
        host_rd(3'd7, 16'h0041, "R10 status ERR");

        // R4/R5 identify
        host_wr(3'd7, 8'hEC);
        observe(K_IRQ, 64'd1, "R4 irq on identify");
        host_rd(3'd7, 16'h0048, "R10 ERR cleared by identify");
        for (int i = 0; i < NWORDS; i++) begin
            host_rd(3'd7, 16'h0048, "R4 status during identify");
            host_rd(3'd0, exp_id(i), $sformatf("R5 identify word %0d", i));
        end
        host_rd(3'd7, 16'h0040, "R4 DRQ cleared after last word");
        host_rd(3'd0, 16'h0000, "R11 data read after identify");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule